// File: doc/BRIEF.md
# PCI target single-read controller

This block is the bus-facing front end of a 32-bit PCI target. It serves read transactions that have exactly one data phase and turns each one into a short handshake with a local back end. When the master pulls frame low, the block latches the address and the command from the multiplexed bus and passes them to the back end. It then checks the address against a set of base address windows. A single-phase memory read or I/O read that falls inside a window of the matching kind is claimed. The block raises a one-hot window-hit vector and gives a one-cycle access strobe. It asserts device select with either medium or slow timing.

After it claims a cycle, the block counts local-ready samples. The first low sample opens a transfer strobe, which tells the back end to present the read word. A second low sample in a row latches that word. In the next cycle the block drives the word on AD together with target ready. When the master has taken the data, the block stops driving AD and drives device select and target ready high for one cycle. In the cycle after that it releases both, clears the hit vector and closes the transfer strobe. Writes, bursts, configuration cycles, parity and target terminations are not handled. A cycle the block does not claim is left to end by master abort.

Top module: `pcitgt_rd`

## Requirements
- R1: One clock edge after frame_n is sampled low while idle, addr_out and cmd_out show the AD and C/BE values sampled at that edge. They hold those values until the next transaction starts.
- R2: A cycle is claimed only if three conditions hold. In the second cycle frame_n is high and irdy_n is low. The command is memory read (4'b0110) to a memory window or I/O read (4'b0010) to an I/O window. The address has the same bits as the window base above the window size. If any condition fails, devsel_oe stays low and the block waits for frame_n and irdy_n to both be high.
- R3: When a cycle is claimed, bar_hit goes one-hot in the cycle after the second bus cycle. Bit 0 is the memory window at 0x1000_0000 (4 KiB) and bit 1 is the I/O window at 0x0000_2000 (256 bytes). The lowest index wins on overlap. acc_n is low for exactly the first cycle of bar_hit.
- R4: With slow timing, device select is driven low one cycle after bar_hit rises. With medium timing it is driven low in the same cycle as bar_hit.
- R5: While device select is asserted, trdy_n stays high until lrdy_n has been sampled low on two consecutive edges. A high sample in between restarts the count.
- R6: xfer_n goes low in the cycle after the first low lrdy_n sample and stays low until the release cycle.
- R7: In the cycle that follows the second consecutive low lrdy_n sample, trdy_n is low, ad_oe is high and ad_out holds the ldata_in value sampled at that edge. Later changes on ldata_in do not alter it.
- R8: In the cycle after the data phase completes (irdy_n and trdy_n both low at an edge), ad_oe is low and devsel_n_out and trdy_n_out are driven high with their enables set. In the following cycle, devsel_oe and trdy_oe are low, bar_hit is zero and xfer_n is high.
- R9: While rst_n is low, every output enable is low, bar_hit is zero and acc_n and xfer_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Master frame, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad_in | input | 32 | AD bus as seen by the target |
| cbe_n | input | 4 | Command / byte-enable lines |
| ad_out | output | 32 | Read word driven onto AD |
| ad_oe | output | 1 | AD output enable |
| devsel_n_out | output | 1 | Device select value |
| devsel_oe | output | 1 | Device select output enable |
| trdy_n_out | output | 1 | Target ready value |
| trdy_oe | output | 1 | Target ready output enable |
| bar_hit | output | NUM_BAR | One-hot window hit to the back end |
| acc_n | output | 1 | One-cycle local access strobe, active low |
| addr_out | output | 32 | Latched address |
| cmd_out | output | 4 | Latched command |
| lrdy_n | input | 1 | Back-end ready, active low |
| ldata_in | input | 32 | Read word from the back end |
| xfer_n | output | 1 | Data-transfer strobe to the back end, active low |

## Verification
On every cycle the assertions check several ordering rules. Target ready may only fall after two low ready samples and after the transfer strobe opened. AD is only driven together with target ready and device select. The access strobe lasts one cycle. Device select is never asserted without exactly one hit bit. The two-step release, and the lag of device select behind the hit vector for the chosen timing mode, are checked as well. Some behaviour only the bench scenarios can show: which addresses and commands are claimed, the values on addr_out and ad_out, and how long the wait states last. The bench also runs a slow and a medium instance side by side to compare when each claims the cycle.

// File: rtl/pcitgt_pkg.sv
package pcitgt_pkg;

  localparam int ADDR_W = 32;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_HIT,
    ST_ACTIVE,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } tgt_state_e;

  // address falls inside the naturally aligned window of 2**bits bytes
  function automatic logic in_window(input logic [ADDR_W-1:0] base,
                                     input logic [5:0] bits,
                                     input logic [ADDR_W-1:0] addr);
    return (addr >> bits) == (base >> bits);
  endfunction

  // command kind agrees with the window kind
  function automatic logic cmd_fits(input logic is_io, input logic [3:0] cmd);
    return is_io ? (cmd == CMD_IO_RD) : (cmd == CMD_MEM_RD);
  endfunction

endpackage

// File: rtl/pcitgt_bar_dec.sv
module pcitgt_bar_dec
  import pcitgt_pkg::*;
#(
  parameter int NUM_BAR = 2,
  parameter logic [NUM_BAR*ADDR_W-1:0] BAR_BASE = '0,
  parameter logic [NUM_BAR*6-1:0]      BAR_BITS = '0,
  parameter logic [NUM_BAR-1:0]        BAR_IO   = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [3:0]         cmd,
  output logic [NUM_BAR-1:0] hit
);

  logic [NUM_BAR-1:0] match;

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_win
    assign match[g] = in_window(BAR_BASE[g*ADDR_W +: ADDR_W], BAR_BITS[g*6 +: 6], addr)
                      && cmd_fits(BAR_IO[g], cmd);
  end

  // lowest index wins so the vector stays one-hot
  always_comb begin
    logic found;
    found = 1'b0;
    hit   = '0;
    for (int i = 0; i < NUM_BAR; i++) begin
      if (!found && match[i]) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcitgt_rdy_trk.sv
module pcitgt_rdy_trk #(
  parameter int READY_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  input  logic lrdy_n,
  output logic xfer,
  output logic run_done
);

  localparam int CW = $clog2(READY_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(READY_RUN - 1);

  logic [CW-1:0] cnt;
  logic          xfer_q;

  assign run_done = arm && !lrdy_n && (cnt == LAST);
  assign xfer     = xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      xfer_q <= 1'b0;
    end else begin
      if (!arm || lrdy_n)  cnt <= '0;
      else if (cnt < LAST) cnt <= cnt + CW'(1);

      if (clr)                 xfer_q <= 1'b0;
      else if (arm && !lrdy_n) xfer_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pcitgt_rd.sv
module pcitgt_rd
  import pcitgt_pkg::*;
#(
  parameter int NUM_BAR = 2,
  parameter logic [NUM_BAR*32-1:0] BAR_BASE = {32'h0000_2000, 32'h1000_0000},
  parameter logic [NUM_BAR*6-1:0]  BAR_BITS = {6'd8, 6'd12},
  parameter logic [NUM_BAR-1:0]    BAR_IO   = 2'b10,
  parameter int DEVSEL_SLOW = 1,
  parameter int READY_RUN   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [31:0]        ad_in,
  input  logic [3:0]         cbe_n,
  output logic [31:0]        ad_out,
  output logic               ad_oe,
  output logic               devsel_n_out,
  output logic               devsel_oe,
  output logic               trdy_n_out,
  output logic               trdy_oe,
  output logic [NUM_BAR-1:0] bar_hit,
  output logic               acc_n,
  output logic [31:0]        addr_out,
  output logic [3:0]         cmd_out,
  input  logic               lrdy_n,
  input  logic [31:0]        ldata_in,
  output logic               xfer_n
);

  localparam logic SLOW = (DEVSEL_SLOW != 0);

  tgt_state_e         state;
  logic [31:0]        addr_q;
  logic [3:0]         cmd_q;
  logic [NUM_BAR-1:0] hit_q;
  logic [NUM_BAR-1:0] dec_hit;
  logic               acc_q;
  logic [31:0]        dat_q;

  // named events for the checker
  logic single_ph;
  logic claim_evt;
  logic rdy_done;
  logic data_done;
  logic xfer_on;

  pcitgt_bar_dec #(
    .NUM_BAR (NUM_BAR),
    .BAR_BASE(BAR_BASE),
    .BAR_BITS(BAR_BITS),
    .BAR_IO  (BAR_IO)
  ) u_dec (
    .addr(addr_q),
    .cmd (cmd_q),
    .hit (dec_hit)
  );

  pcitgt_rdy_trk #(
    .READY_RUN(READY_RUN)
  ) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (state == ST_ACTIVE),
    .clr     (state == ST_TURN),
    .lrdy_n  (lrdy_n),
    .xfer    (xfer_on),
    .run_done(rdy_done)
  );

  assign single_ph = frame_n && !irdy_n;
  assign claim_evt = (state == ST_DECODE) && single_ph && (|dec_hit);
  assign data_done = (state == ST_DATA) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      cmd_q  <= '0;
      hit_q  <= '0;
      acc_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      acc_q <= claim_evt;
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            addr_q <= ad_in;
            cmd_q  <= cbe_n;
            state  <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (claim_evt) begin
            hit_q <= dec_hit;
            state <= SLOW ? ST_HIT : ST_ACTIVE;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_HIT:    state <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (rdy_done) begin
            dat_q <= ldata_in;
            state <= ST_DATA;
          end
        end
        ST_DATA: if (data_done) state <= ST_TURN;
        ST_TURN: begin
          hit_q <= '0;
          state <= ST_IDLE;
        end
        ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign addr_out     = addr_q;
  assign cmd_out      = cmd_q;
  assign bar_hit      = hit_q;
  assign acc_n        = !acc_q;
  assign xfer_n       = !xfer_on;
  assign ad_out       = dat_q;
  assign ad_oe        = (state == ST_DATA);
  assign devsel_oe    = (state == ST_ACTIVE) || (state == ST_DATA) || (state == ST_TURN);
  assign devsel_n_out = !((state == ST_ACTIVE) || (state == ST_DATA));
  assign trdy_oe      = devsel_oe;
  assign trdy_n_out   = !(state == ST_DATA);

endmodule

// File: rtl/pcitgt_rd_chk.sv
module pcitgt_rd_chk #(
  parameter int NUM_BAR     = 2,
  parameter int DEVSEL_SLOW = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lrdy_n,
  input logic [31:0]        ad_out,
  input logic               ad_oe,
  input logic               devsel_n_out,
  input logic               devsel_oe,
  input logic               trdy_n_out,
  input logic               trdy_oe,
  input logic [NUM_BAR-1:0] bar_hit,
  input logic               acc_n,
  input logic               xfer_n,
  input logic               claim_evt,
  input logic               data_done
);

  p_trdy_two_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n_out) |-> (!$past(lrdy_n) && !$past(lrdy_n, 2)));

  p_xfer_before_trdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n_out) |-> !$past(xfer_n));

  p_ad_with_trdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!trdy_n_out && trdy_oe && !devsel_n_out && devsel_oe));

  p_ad_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_out));

  p_acc_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_n |=> acc_n);

  p_acc_from_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_n) |-> $past(claim_evt));

  p_devsel_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_oe && !devsel_n_out) |-> ($countones(bar_hit) == 1));

  p_turn_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ad_oe) |-> ($past(data_done) && devsel_oe && devsel_n_out && trdy_oe && trdy_n_out));

  p_turn_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_oe) |-> ($past(devsel_n_out) && !trdy_oe && (bar_hit == '0) && xfer_n));

  if (DEVSEL_SLOW != 0) begin : g_slow
    p_devsel_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devsel_oe) |-> ($past(bar_hit) != '0));
  end else begin : g_med
    p_devsel_med_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(devsel_oe) |-> (($past(bar_hit) == '0) && (bar_hit != '0)));
  end

endmodule

bind pcitgt_rd pcitgt_rd_chk #(
  .NUM_BAR    (NUM_BAR),
  .DEVSEL_SLOW(DEVSEL_SLOW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lrdy_n      (lrdy_n),
  .ad_out      (ad_out),
  .ad_oe       (ad_oe),
  .devsel_n_out(devsel_n_out),
  .devsel_oe   (devsel_oe),
  .trdy_n_out  (trdy_n_out),
  .trdy_oe     (trdy_oe),
  .bar_hit     (bar_hit),
  .acc_n       (acc_n),
  .xfer_n      (xfer_n),
  .claim_evt   (claim_evt),
  .data_done   (data_done)
);

// File: tb/pcitgt_rd_bench.sv
module pcitgt_rd_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [3:0]  waits;
    logic [31:0] data;
    logic [1:0]  hit;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h1000_0040, 4'b0110, 4'd0, 32'hA5A5_0001, 2'b01},
    '{32'h0000_20F0, 4'b0010, 4'd2, 32'h5A5A_0002, 2'b10},
    '{32'h1000_0FFC, 4'b0110, 4'd3, 32'h1234_5678, 2'b01},
    '{32'h1000_1000, 4'b0110, 4'd0, 32'h0,         2'b00},
    '{32'h1000_0040, 4'b0111, 4'd0, 32'h0,         2'b00},
    '{32'h0000_2004, 4'b0110, 4'd0, 32'h0,         2'b00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, lrdy_n = 1'b1;
  logic [31:0] ad_in = '0, ldata_in = '0;
  logic [3:0]  cbe_n = '1;

  logic [31:0] ad_out, addr_out, m_ad_out, m_addr_out;
  logic        ad_oe, devsel_n_out, devsel_oe, trdy_n_out, trdy_oe, acc_n, xfer_n;
  logic        m_ad_oe, m_devsel_n, m_devsel_oe, m_trdy_n, m_trdy_oe, m_acc_n, m_xfer_n;
  logic [1:0]  bar_hit, m_bar_hit;
  logic [3:0]  cmd_out, m_cmd_out;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcitgt_rd #(.DEVSEL_SLOW(1)) u_pcitgt_rd (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n_out(devsel_n_out), .devsel_oe(devsel_oe),
    .trdy_n_out(trdy_n_out), .trdy_oe(trdy_oe), .bar_hit(bar_hit),
    .acc_n(acc_n), .addr_out(addr_out), .cmd_out(cmd_out),
    .lrdy_n(lrdy_n), .ldata_in(ldata_in), .xfer_n(xfer_n)
  );

  pcitgt_rd #(.DEVSEL_SLOW(0)) u_med (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(m_ad_out), .ad_oe(m_ad_oe),
    .devsel_n_out(m_devsel_n), .devsel_oe(m_devsel_oe),
    .trdy_n_out(m_trdy_n), .trdy_oe(m_trdy_oe), .bar_hit(m_bar_hit),
    .acc_n(m_acc_n), .addr_out(m_addr_out), .cmd_out(m_cmd_out),
    .lrdy_n(lrdy_n), .ldata_in(ldata_in), .xfer_n(m_xfer_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one read, driven at falling edges; outputs checked at falling edges
  task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd,
                         input int waits, input logic [31:0] data,
                         input logic [1:0] exp_hit, input bit burst, input bit glitch);
    @(negedge clk);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    chk("R1 addr_out", addr_out, addr);
    chk("R1 cmd_out", {28'd0, cmd_out}, {28'd0, cmd});
    frame_n = burst ? 1'b0 : 1'b1; irdy_n = 1'b0; ad_in = 32'hDEAD_BEEF; cbe_n = 4'h0;
    @(negedge clk);
    chk("R3 bar_hit", {30'd0, bar_hit}, {30'd0, exp_hit});
    chk("R4 slow devsel_oe late", {31'd0, devsel_oe}, 32'd0);
    chk("R4 medium devsel", {30'd0, m_devsel_oe, m_devsel_n}, (exp_hit != 0) ? 32'd2 : 32'd1);
    if (exp_hit == 2'b00) begin
      chk("R3 acc_n idle", {31'd0, acc_n}, 32'd1);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R2 no devsel", {30'd0, devsel_oe, m_devsel_oe}, 32'd0);
      end
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
      chk("R2 idle hit", {30'd0, bar_hit}, 32'd0);
      return;
    end
    chk("R3 acc_n low", {31'd0, acc_n}, 32'd0);
    @(negedge clk);
    chk("R3 acc_n one cycle", {31'd0, acc_n}, 32'd1);
    chk("R4 slow devsel", {29'd0, devsel_oe, devsel_n_out, trdy_n_out}, 32'd5);
    for (int w = 0; w < waits; w++) begin
      lrdy_n = 1'b1;
      @(negedge clk);
      chk("R5 wait trdy", {30'd0, trdy_n_out, xfer_n}, 32'd3);
    end
    if (glitch) begin
      lrdy_n = 1'b0;
      @(negedge clk);
      chk("R6 xfer on", {31'd0, xfer_n}, 32'd0);
      lrdy_n = 1'b1;
      @(negedge clk);
      chk("R5 restart trdy", {31'd0, trdy_n_out}, 32'd1);
    end
    lrdy_n = 1'b0; ldata_in = data;
    @(negedge clk);
    chk("R6 xfer low", {31'd0, xfer_n}, 32'd0);
    chk("R5 trdy after one", {31'd0, trdy_n_out}, 32'd1);
    @(negedge clk);
    chk("R7 trdy ad_oe", {30'd0, trdy_n_out, ad_oe}, 32'd1);
    chk("R7 ad_out", ad_out, data);
    lrdy_n = 1'b1; ldata_in = ~data;
    @(negedge clk);
    chk("R8 turn one", {26'd0, ad_oe, devsel_oe, devsel_n_out, trdy_oe, trdy_n_out, xfer_n},
        32'h1E);
    irdy_n = 1'b1;
    @(negedge clk);
    chk("R8 release", {27'd0, devsel_oe, trdy_oe, bar_hit, xfer_n}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset oe", {29'd0, ad_oe, devsel_oe, trdy_oe}, 32'd0);
    chk("R9 reset hit/strobes", {28'd0, bar_hit, acc_n, xfer_n}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_txn(VEC[i].addr, VEC[i].cmd, int'(VEC[i].waits), VEC[i].data, VEC[i].hit, 1'b0, 1'b0);
    // burst-style cycle to a valid window is not claimed (R2)
    run_txn(32'h1000_0010, 4'b0110, 0, 32'h0, 2'b00, 1'b1, 1'b0);
    // broken local ready run restarts the count (R5)
    run_txn(32'h0000_2080, 4'b0010, 1, 32'hCAFE_0007, 2'b10, 1'b0, 1'b1);
    // back-to-back read after release
    run_txn(32'h1000_0800, 4'b0110, 0, 32'h0BAD_F00D, 2'b01, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule